// File: doc/BRIEF.md
# Oversampling Serial Receiver with Retry NACK

This block recovers characters from an asynchronous serial line. The line is first passed through a synchronizer, then sampled once per pulse of an external oversampling tick. An optional 2-of-3 majority filter can clean those samples. A runtime control sets the bit period to 16 or 8 ticks. The receiver confirms a start bit at its middle sample and then samples every data, parity and stop bit at its middle tick. It presents the character right-aligned with a one-cycle valid strobe, together with parity-error and framing-error flags. The character length, parity type, bit order and data polarity are inputs, and they must match the far-end transmitter.

For a half-duplex smart-card style line, a parity error can cause a NACK request. The request is held for one bit period, starting at the middle of the stop slot, and an external pad driver pulls the line low while it is high. A NACK policy unit can suppress NACKs entirely. It can also count consecutive parity errors, so that NACKs stop once a programmable 3-bit cap is reached and an iteration flag is raised instead.

The controller has six states: IDLE, START, DATA, PARITY, STOP and NACK. The transitions are:
- IDLE to START when a tick sees the line low.
- START to DATA when the middle start sample is low.
- START to IDLE when the middle start sample is high (a rejected start).
- DATA to PARITY after the last data bit when parity is enabled.
- DATA to STOP after the last data bit when parity is disabled.
- PARITY to STOP after the parity sample.
- STOP to NACK when the policy unit grants a NACK.
- STOP to IDLE when no NACK is granted.
- NACK to IDLE after one full bit period.

Top module: `osr_receiver`

## Requirements
- R1: After reset, rx_valid, rx_perr, rx_ferr, nack_drive and iter_flag are 0 and rx_data is 0.
- R2: With cfg_over8 = 0 a bit period is 16 os_tick pulses; with cfg_over8 = 1 it is 8. This sets the data sampling interval and the NACK duration.
- R3: With cfg_filter_en = 1 the sampled line is the 2-of-3 majority of the last three tick samples, so an isolated single-sample glitch does not corrupt a character. With cfg_filter_en = 0 the latest sample is used directly.
- R4: A start is accepted only if the line is still low at the middle sample of the start bit (tick 8 of 16 or 4 of 8 after detection). Otherwise the receiver returns to IDLE without a strobe.
- R5: The character length is 5 + cfg_len (cfg_len 0..3 gives 5..8 bits), or 9 when cfg_nine = 1. Data is right-aligned in rx_data with the unused upper bits 0. The first bit on the line is bit 0 when cfg_msb_first = 0, and the top bit of the character when cfg_msb_first = 1.
- R6: cfg_parity codes are 0 even, 1 odd, 2 parity bit must be 0, 3 parity bit must be 1, and 4..7 no parity slot. rx_perr reports a parity mismatch and is 0 when there is no parity slot.
- R7: With cfg_invert = 1, every data bit and the parity bit are complemented before storage and before the parity check.
- R8: rx_valid pulses for exactly one clock at the middle of the first stop bit, with rx_data, rx_perr and rx_ferr updated in that cycle and held until the next character. rx_ferr = 1 when that stop sample is low.
- R9: With NACK limiting off and no inhibit, every character with a parity error raises nack_drive in the same cycle as rx_valid, and holds it for exactly one bit period (64 clocks at 16x and 32 clocks at 8x with a tick every 4 clocks).
- R10: With cfg_nack_inhibit = 1, nack_drive never rises, and rx_perr is still reported.
- R11: With cfg_nack_limit_en = 1, a parity-error character produces a NACK and increments a consecutive-error count while the count is below cfg_nack_cap. When the count equals cfg_nack_cap, the character produces no NACK and iter_flag is set.
- R12: A character received without a parity error clears the consecutive-error count and iter_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial line, idle high |
| os_tick | input | 1 | One-clock pulse at the oversampling rate |
| cfg_over8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| cfg_filter_en | input | 1 | Enable the 2-of-3 majority filter |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_nine | input | 1 | Force a 9-bit character |
| cfg_parity | input | 3 | Parity code (see R6) |
| cfg_msb_first | input | 1 | Most significant bit first on the line |
| cfg_invert | input | 1 | Complement data and parity bits |
| cfg_nack_inhibit | input | 1 | Suppress all NACKs |
| cfg_nack_limit_en | input | 1 | Enable the consecutive-error cap |
| cfg_nack_cap | input | 3 | Maximum number of NACKs in a row |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_perr | output | 1 | Parity error for the last character |
| rx_ferr | output | 1 | Framing error for the last character |
| nack_drive | output | 1 | Request to pull the line low for a NACK |
| iter_flag | output | 1 | Consecutive-error cap reached |

## Verification
The in-line assertions check the following on every cycle:
- rx_valid stays a single-cycle strobe.
- A NACK only starts together with a strobed parity error, and never while inhibit is set.
- Entry to DATA always follows a low middle start sample.
- The filtered line only moves after a tick.
- iter_flag rises only on a capped parity-error character and falls only on a clean one.

The bench scenarios show the behaviours that depend on the data values and on timing over a whole character:
- Bit ordering, lengths, parity codes and inversion.
- The exact NACK duration at both oversampling rates.
- The counting sequence of the cap.
- Rejection of a short start pulse.
- Recovery of a character through periodic single-sample glitches with the filter on.

// File: rtl/osr_pkg.sv
package osr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_NACK
    } rx_state_e;

    localparam logic [2:0] PAR_EVEN = 3'd0;
    localparam logic [2:0] PAR_ODD  = 3'd1;
    localparam logic [2:0] PAR_ZERO = 3'd2;
    localparam logic [2:0] PAR_ONE  = 3'd3;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction

endpackage

// File: rtl/osr_line_filter.sv
module osr_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic tick,
    input  logic filt_en,
    output logic line_q
);
    import osr_pkg::*;

    localparam int HIST = 3;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST-1:0]        hist_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hist_q <= '1;
        else if (tick) hist_q <= {hist_q[HIST-2:0], sync_q[SYNC_STAGES-1]};
    end

    assign line_q = filt_en ? maj3(hist_q) : hist_q[0];

    // R3: the value seen by the receiver only moves after an oversampling tick
    assert_filter_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $stable(filt_en)) |-> $stable(line_q));

endmodule

// File: rtl/osr_nack_ctrl.sv
module osr_nack_ctrl #(
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic              char_perr,
    input  logic              inhibit,
    input  logic              limit_en,
    input  logic [ITER_W-1:0] cap,
    output logic              nack_go,
    output logic              iter_flag
);
    logic [ITER_W-1:0] run_q;
    logic              at_cap;

    assign at_cap  = (run_q >= cap);
    assign nack_go = char_done && char_perr && !inhibit && (!limit_en || !at_cap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            iter_flag <= 1'b0;
        end else if (char_done) begin
            if (!char_perr) begin
                run_q     <= '0;
                iter_flag <= 1'b0;
            end else if (limit_en) begin
                if (at_cap) iter_flag <= 1'b1;
                else        run_q     <= run_q + 1'b1;
            end
        end
    end

    // R11: the flag only rises on a parity-error character with the cap active
    assert_iter_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iter_flag) |-> $past(char_done && char_perr && limit_en));

    // R12: the flag only falls on a clean character
    assert_iter_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iter_flag) |-> $past(char_done && !char_perr));

endmodule

// File: rtl/osr_rx_fsm.sv
module osr_rx_fsm #(
    parameter int OS_HI    = 16,
    parameter int OS_LO    = 8,
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line_s,
    input  logic                cfg_over8,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_nine,
    input  logic [2:0]          cfg_parity,
    input  logic                cfg_msb_first,
    input  logic                cfg_invert,
    input  logic                nack_go,
    output logic                char_done,
    output logic                char_perr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                nack_drive
);
    import osr_pkg::*;

    localparam int CW = $clog2(OS_HI);
    localparam int BW = $clog2(MAX_BITS + 1);

    rx_state_e             state_q, state_d;
    logic [CW-1:0]         cnt_q;
    logic [BW-1:0]         bit_q;
    logic [MAX_BITS-1:0]   shift_q;
    logic                  acc_q;
    logic                  perr_q;

    logic [CW-1:0]         os_last, half_m1;
    logic [BW-1:0]         n_bits, wr_idx;
    logic                  has_par, bit_eff, slot_end, mid_start, last_bit, par_bad;

    assign os_last   = cfg_over8 ? CW'(OS_LO - 1)     : CW'(OS_HI - 1);
    assign half_m1   = cfg_over8 ? CW'(OS_LO / 2 - 1) : CW'(OS_HI / 2 - 1);
    assign n_bits    = cfg_nine ? BW'(MAX_BITS) : BW'(5) + BW'(cfg_len);
    assign has_par   = (cfg_parity < 3'd4);
    assign bit_eff   = line_s ^ cfg_invert;
    assign slot_end  = tick && (cnt_q == os_last);
    assign mid_start = tick && (cnt_q == half_m1);
    assign last_bit  = (bit_q == n_bits - BW'(1));
    assign wr_idx    = cfg_msb_first ? (n_bits - BW'(1) - bit_q) : bit_q;
    assign char_done = (state_q == ST_STOP) && slot_end;
    assign char_perr = perr_q;

    always_comb begin
        unique case (cfg_parity)
            PAR_EVEN: par_bad = acc_q ^ bit_eff;
            PAR_ODD:  par_bad = ~(acc_q ^ bit_eff);
            PAR_ZERO: par_bad = bit_eff;
            PAR_ONE:  par_bad = ~bit_eff;
            default:  par_bad = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !line_s) state_d = ST_START;
            ST_START:  if (mid_start) state_d = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (slot_end && last_bit) state_d = has_par ? ST_PARITY : ST_STOP;
            ST_PARITY: if (slot_end) state_d = ST_STOP;
            ST_STOP:   if (slot_end) state_d = nack_go ? ST_NACK : ST_IDLE;
            ST_NACK:   if (slot_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath: tick counter, bit counter, shift register, parity accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            acc_q   <= 1'b0;
            perr_q  <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    shift_q <= '0;
                    acc_q   <= 1'b0;
                    perr_q  <= 1'b0;
                end
                ST_START: begin
                    cnt_q <= mid_start ? '0 : cnt_q + 1'b1;
                end
                ST_DATA: begin
                    if (slot_end) begin
                        cnt_q           <= '0;
                        shift_q[wr_idx] <= bit_eff;
                        acc_q           <= acc_q ^ bit_eff;
                        bit_q           <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (slot_end) begin
                        cnt_q  <= '0;
                        perr_q <= par_bad;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP, ST_NACK: begin
                    cnt_q <= slot_end ? '0 : cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_perr    <= 1'b0;
            rx_ferr    <= 1'b0;
            nack_drive <= 1'b0;
        end else begin
            rx_valid <= char_done;
            if (char_done) begin
                rx_data <= shift_q;
                rx_perr <= perr_q;
                rx_ferr <= !line_s;
            end
            if (char_done && nack_go)
                nack_drive <= 1'b1;
            else if (state_q == ST_NACK && slot_end)
                nack_drive <= 1'b0;
        end
    end

    // R8: the character strobe lasts a single cycle
    assert_valid_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: data reception only starts after a low middle start sample
    assert_start_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(line_s));

    // R9: a NACK begins together with a strobed parity error
    assert_nack_on_perr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_drive) |-> (rx_valid && rx_perr));

endmodule

// File: rtl/osr_receiver.sv
module osr_receiver #(
    parameter int OS_HI       = 16,
    parameter int OS_LO       = 8,
    parameter int MAX_BITS    = 9,
    parameter int ITER_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic                os_tick,
    input  logic                cfg_over8,
    input  logic                cfg_filter_en,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_nine,
    input  logic [2:0]          cfg_parity,
    input  logic                cfg_msb_first,
    input  logic                cfg_invert,
    input  logic                cfg_nack_inhibit,
    input  logic                cfg_nack_limit_en,
    input  logic [ITER_W-1:0]   cfg_nack_cap,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                nack_drive,
    output logic                iter_flag
);
    logic line_s, char_done, char_perr, nack_go;

    osr_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (rx_line),
        .tick     (os_tick),
        .filt_en  (cfg_filter_en),
        .line_q   (line_s)
    );

    osr_rx_fsm #(.OS_HI(OS_HI), .OS_LO(OS_LO), .MAX_BITS(MAX_BITS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (os_tick),
        .line_s        (line_s),
        .cfg_over8     (cfg_over8),
        .cfg_len       (cfg_len),
        .cfg_nine      (cfg_nine),
        .cfg_parity    (cfg_parity),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .nack_go       (nack_go),
        .char_done     (char_done),
        .char_perr     (char_perr),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_perr       (rx_perr),
        .rx_ferr       (rx_ferr),
        .nack_drive    (nack_drive)
    );

    osr_nack_ctrl #(.ITER_W(ITER_W)) u_nack (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .char_perr (char_perr),
        .inhibit   (cfg_nack_inhibit),
        .limit_en  (cfg_nack_limit_en),
        .cap       (cfg_nack_cap),
        .nack_go   (nack_go),
        .iter_flag (iter_flag)
    );

    // R10: an inhibited receiver never starts a NACK
    assert_inhibit_no_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_drive) |-> !$past(cfg_nack_inhibit));

endmodule

// File: tb/osr_receiver_bench.sv
`timescale 1ns/1ps
module osr_receiver_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] div_q;
    logic       os_tick;
    logic       over8 = 0, filt = 0, nine = 0, msbf = 0, inv = 0, inh = 0, lim = 0;
    logic [1:0] len = 2'd3;
    logic [2:0] par = 3'd0;
    logic [2:0] cap = 3'd0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, nack_drive, iter_flag;

    int checks = 0, errors = 0, gidx = 0;
    int vcnt = 0, nack_cyc = 0;
    logic [8:0] got_data;
    logic got_perr, got_ferr, got_nack;
    bit done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) div_q <= 2'd0;
        else        div_q <= div_q + 2'd1;
    end
    assign os_tick = (div_q == 2'd3);

    osr_receiver u_osr_receiver (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .cfg_over8(over8), .cfg_filter_en(filt), .cfg_len(len), .cfg_nine(nine),
        .cfg_parity(par), .cfg_msb_first(msbf), .cfg_invert(inv),
        .cfg_nack_inhibit(inh), .cfg_nack_limit_en(lim), .cfg_nack_cap(cap),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .nack_drive(nack_drive), .iter_flag(iter_flag)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            if (vcnt == 0) begin
                got_data = rx_data;
                got_perr = rx_perr;
                got_ferr = rx_ferr;
                got_nack = nack_drive;
            end
            vcnt++;
        end
        if (nack_drive) nack_cyc++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_wait(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!os_tick) @(negedge clk);
        end
    endtask

    function automatic int n_len();
        return nine ? 9 : 5 + int'(len);
    endfunction

    function automatic int n_os();
        return over8 ? 8 : 16;
    endfunction

    function automatic logic [8:0] dmask();
        return 9'((10'd1 << n_len()) - 10'd1);
    endfunction

    function automatic logic par_bit(input logic [8:0] d);
        logic x = ^(d & dmask());
        case (par)
            3'd0: return x;
            3'd1: return ~x;
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive_slot(input logic v, input int n, input bit noisy);
        for (int k = 0; k < n; k++) begin
            rx_line = v ^ (noisy && (gidx % 3 == 2));
            gidx++;
            tick_wait(1);
        end
    endtask

    task automatic send_char(input logic [8:0] d, input bit bad_par, input bit stop_low, input bit noisy);
        int n = n_os();
        int l = n_len();
        vcnt = 0;
        nack_cyc = 0;
        drive_slot(1'b0, n, noisy);
        for (int j = 0; j < l; j++) begin
            int idx = msbf ? l - 1 - j : j;
            drive_slot(d[idx] ^ inv, n, noisy);
        end
        if (par < 3'd4) drive_slot(par_bit(d) ^ inv ^ bad_par, n, noisy);
        drive_slot(stop_low ? 1'b0 : 1'b1, n, noisy);
        drive_slot(1'b1, 3 * n, 1'b0);
        if (stop_low) drive_slot(1'b1, 12 * n, 1'b0);
    endtask

    task automatic expect_char(input string req, input logic [8:0] d, input bit perr,
                               input bit ferr, input bit nack);
        int nexp = nack ? n_os() * 4 : 0;
        chk(vcnt >= 1, {req, " strobe"}, vcnt, 1);
        chk(got_data == (d & dmask()), {req, " data"}, int'(got_data), int'(d & dmask()));
        chk(got_perr == perr, {req, " perr"}, int'(got_perr), int'(perr));
        chk(got_ferr == ferr, {req, " ferr"}, int'(got_ferr), int'(ferr));
        chk(got_nack == nack, {req, " nack with strobe"}, int'(got_nack), int'(nack));
        chk(nack_cyc == nexp, {req, " nack length"}, nack_cyc, nexp);
    endtask

    task automatic t_reset();
        chk(rx_valid == 0 && rx_perr == 0 && rx_ferr == 0, "R1 flags", int'(rx_valid | rx_perr | rx_ferr), 0);
        chk(nack_drive == 0 && iter_flag == 0, "R1 nack/iter", int'(nack_drive | iter_flag), 0);
        chk(rx_data == 0, "R1 data", int'(rx_data), 0);
    endtask

    task automatic t_basic();
        over8 = 0; len = 2'd3; nine = 0; par = 3'd0; msbf = 0; inv = 0;
        send_char(9'h0A5, 0, 0, 0); expect_char("R5 8b even lsb", 9'h0A5, 0, 0, 0);
        par = 3'd1;
        send_char(9'h03C, 0, 0, 0); expect_char("R6 odd", 9'h03C, 0, 0, 0);
    endtask

    task automatic t_short_msb_8x();
        over8 = 1; len = 2'd0; par = 3'd1; msbf = 1;
        send_char(9'h013, 0, 0, 0); expect_char("R2 R5 5b msb 8x", 9'h013, 0, 0, 0);
        len = 2'd2; par = 3'd4; msbf = 0;
        send_char(9'h05B, 0, 0, 0); expect_char("R5 7b none 8x", 9'h05B, 0, 0, 0);
        over8 = 0; msbf = 0;
    endtask

    task automatic t_nine();
        nine = 1; par = 3'd4; msbf = 1;
        send_char(9'h1A3, 0, 0, 0); expect_char("R5 9b msb", 9'h1A3, 0, 0, 0);
        nine = 0; msbf = 0;
    endtask

    task automatic t_forced_parity();
        len = 2'd3; inh = 1;
        par = 3'd2;
        send_char(9'h0F1, 0, 0, 0); expect_char("R6 forced0 ok", 9'h0F1, 0, 0, 0);
        send_char(9'h0F1, 1, 0, 0); expect_char("R6 forced0 bad", 9'h0F1, 1, 0, 0);
        par = 3'd3;
        send_char(9'h00E, 0, 0, 0); expect_char("R6 forced1 ok", 9'h00E, 0, 0, 0);
        send_char(9'h00E, 1, 0, 0); expect_char("R6 R10 forced1 bad inhibited", 9'h00E, 1, 0, 0);
        inh = 0;
    endtask

    task automatic t_invert();
        par = 3'd0; inv = 1;
        send_char(9'h03C, 0, 0, 0); expect_char("R7 inverted", 9'h03C, 0, 0, 0);
        send_char(9'h081, 1, 0, 0); expect_char("R7 R9 inverted bad parity", 9'h081, 1, 0, 1);
        inv = 0;
    endtask

    task automatic t_nack_plain();
        par = 3'd0; lim = 0; inh = 0;
        for (int i = 0; i < 3; i++) begin
            send_char(9'h055, 1, 0, 0); expect_char("R9 repeated nack", 9'h055, 1, 0, 1);
            chk(iter_flag == 0, "R9 no iter flag", int'(iter_flag), 0);
        end
        over8 = 1;
        send_char(9'h055, 1, 0, 0); expect_char("R2 R9 nack 8x", 9'h055, 1, 0, 1);
        over8 = 0;
        inh = 1;
        send_char(9'h055, 1, 0, 0); expect_char("R10 inhibit", 9'h055, 1, 0, 0);
        inh = 0;
        send_char(9'h055, 0, 0, 0); expect_char("R12 clean", 9'h055, 0, 0, 0);
    endtask

    task automatic t_cap();
        lim = 1; cap = 3'd2; par = 3'd0;
        send_char(9'h0C3, 1, 0, 0); expect_char("R11 first", 9'h0C3, 1, 0, 1);
        chk(iter_flag == 0, "R11 flag after first", int'(iter_flag), 0);
        send_char(9'h0C3, 1, 0, 0); expect_char("R11 second", 9'h0C3, 1, 0, 1);
        chk(iter_flag == 0, "R11 flag after second", int'(iter_flag), 0);
        send_char(9'h0C3, 1, 0, 0); expect_char("R11 capped", 9'h0C3, 1, 0, 0);
        chk(iter_flag == 1, "R11 flag at cap", int'(iter_flag), 1);
        send_char(9'h0C3, 1, 0, 0); expect_char("R11 still capped", 9'h0C3, 1, 0, 0);
        chk(iter_flag == 1, "R11 flag held", int'(iter_flag), 1);
        send_char(9'h0C3, 0, 0, 0); expect_char("R12 clean clears", 9'h0C3, 0, 0, 0);
        chk(iter_flag == 0, "R12 flag cleared", int'(iter_flag), 0);
        send_char(9'h0C3, 1, 0, 0); expect_char("R12 count restarted", 9'h0C3, 1, 0, 1);
        send_char(9'h0C3, 0, 0, 0); expect_char("R12 clean again", 9'h0C3, 0, 0, 0);
        cap = 3'd0;
        send_char(9'h012, 1, 0, 0); expect_char("R11 cap zero", 9'h012, 1, 0, 0);
        chk(iter_flag == 1, "R11 cap zero flag", int'(iter_flag), 1);
        send_char(9'h012, 0, 0, 0); expect_char("R12 cap zero clear", 9'h012, 0, 0, 0);
        chk(iter_flag == 0, "R12 cap zero flag clear", int'(iter_flag), 0);
        lim = 0;
    endtask

    task automatic t_frame();
        par = 3'd4; len = 2'd3;
        send_char(9'h0B6, 0, 1, 0); expect_char("R8 framing error", 9'h0B6, 0, 1, 0);
        send_char(9'h0B6, 0, 0, 0); expect_char("R8 framing recovered", 9'h0B6, 0, 0, 0);
    endtask

    task automatic t_start_reject();
        filt = 0; vcnt = 0;
        rx_line = 1'b0; tick_wait(3);
        rx_line = 1'b1; tick_wait(40);
        chk(vcnt == 0, "R4 short start rejected", vcnt, 0);
        send_char(9'h071, 0, 0, 0); expect_char("R4 next start accepted", 9'h071, 0, 0, 0);
    endtask

    task automatic t_filter();
        filt = 1; vcnt = 0;
        rx_line = 1'b0; tick_wait(1);
        rx_line = 1'b1; tick_wait(40);
        chk(vcnt == 0, "R3 single glitch ignored", vcnt, 0);
        par = 3'd0; len = 2'd3;
        gidx = 0;
        send_char(9'h0E7, 0, 0, 1); expect_char("R3 noisy char filtered", 9'h0E7, 0, 0, 0);
        send_char(9'h019, 0, 0, 1); expect_char("R3 noisy char 2", 9'h019, 0, 0, 0);
        filt = 0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick_wait(4);
        t_basic();
        t_short_msb_8x();
        t_nine();
        t_forced_parity();
        t_invert();
        t_nack_plain();
        t_cap();
        t_frame();
        t_start_reject();
        t_filter();
        done = 1;
        report();
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

endmodule